// File: doc/BRIEF.md
# Paired Debug Trigger Resolver

This block keeps the settings of ten hardware debug triggers and turns the raw match results of one instruction into trap decisions. Comparators elsewhere in the pipeline produce a hit bit per trigger. The block qualifies each hit with the instruction's valid flag and the trigger's enable. It then applies the pairing rules and reports which triggers fire, whether the trap is taken on the current instruction, and whether a trap is owed to the next one.

The triggers form five fixed pairs, (0,1) through (8,9). The pair kinds are fetch+fetch, store+store, load+load, fetch+store and fetch+load. A chained pair acts as one joint condition. Writes come through a single-beat port that updates one trigger per cycle. That trigger's compare value, match type, select and action settings are driven back out so the comparators can use them.

Top module: `trig_pair_resolver`

## Requirements
- R1: After reset every trigger is disabled, unchained and has timing 0, every stored match type, select, action and compare value reads zero, `next_pending` is 0, and no trigger fires for any hit pattern.
- R2: With `cfg_we` high and `cfg_idx` below 10, the addressed trigger's enable, timing, match type, select, action and compare value take the input values from the following cycle. Trigger t appears at `mtype_q[2t+1:2t]`, `select_q[t]`, `action_q[t]` and `cmp_q[64t+63:64t]`. A write with an index of 10 or more changes nothing.
- R3: In an unchained pair, `fire[t]` equals `insn_valid` AND `hit_raw[t]` AND the enable of trigger t.
- R4: In a chained pair, both triggers fire when both are enabled and both hit in the same valid instruction. Otherwise neither fires, and that includes the case where a member is disabled.
- R5: A chained pair whose two timing bits differ never fires, even when both members are enabled and hit.
- R6: The chain field of a write to trigger 2 (the store+store pair) is ignored, so triggers 2 and 3 always fire independently.
- R7: The chain state of pair i is taken only from writes to the even trigger 2i. The chain field of a write to an odd index has no effect.
- R8: `trap_now` is 1 when any firing trigger has timing 0. `trap_next_req` is 1 when any firing trigger has timing 1. Both are combinational in the current cycle.
- R9: `next_pending` goes to 1 in the cycle after a valid instruction raises `trap_next_req`. It holds through cycles without a valid instruction. It is then reloaded from `trap_next_req` by the next valid instruction, so it clears when that instruction does not request a next-instruction trap.
- R10: `fetch_hit` is the OR of the valid, enabled hits of triggers 0, 1, 6 and 8. `mem_hit` is the same OR over triggers 2, 3, 4, 5, 7 and 9. `any_hit` is the OR of the two.
- R11: While `insn_valid` is 0, no trigger fires and `trap_now` and `trap_next_req` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Trigger addressed by the write |
| cfg_mtype | input | 2 | Match type to store |
| cfg_select | input | 1 | Select bit to store |
| cfg_timing | input | 1 | 0: trap at this instruction, 1: trap at the next |
| cfg_action | input | 1 | Action bit to store |
| cfg_chain | input | 1 | Chain request (honoured on even indices only) |
| cfg_enable | input | 1 | Trigger enable |
| cfg_cmp | input | 64 | Compare value to store |
| insn_valid | input | 1 | The current instruction is valid |
| hit_raw | input | 10 | Raw comparator hit per trigger |
| fire | output | 10 | Per-trigger fire decision |
| trap_now | output | 1 | Trap on the current instruction |
| trap_next_req | output | 1 | Trap requested on the following instruction |
| next_pending | output | 1 | Registered next-instruction trap awaiting a valid instruction |
| fetch_hit | output | 1 | Some fetch-side trigger hit |
| mem_hit | output | 1 | Some memory-side trigger hit |
| any_hit | output | 1 | Some trigger hit |
| mtype_q | output | 20 | Stored match types, 2 bits per trigger |
| select_q | output | 10 | Stored select bits |
| action_q | output | 10 | Stored action bits |
| cmp_q | output | 640 | Stored compare values, 64 bits per trigger |

## Verification
The bench hits one member of a chained pair on its own. A resolver that ORs instead of ANDs would fire there. It also hits both members with disagreeing timing, which a design that ignored the mismatch rule would let through as a trap. Chain requests are written to the store+store pair and to odd indices, and a wrong design would then silence a lone hit that should fire. A next-instruction trap is held across invalid cycles and must drop after the next valid instruction. Writes to out-of-range indices must leave every stored field untouched.

// File: rtl/trig_pkg.sv
`timescale 1ns/1ps
package trig_pkg;

  localparam int MT_W = 2;

  typedef struct packed {
    logic [MT_W-1:0] mtype;
    logic            sel;
    logic            timing;
    logic            action;
    logic            enable;
  } trig_ctl_t;

  // Resolve one pair: ha/hb are qualified hits, ta/tb the timing bits.
  // Result bit 0 belongs to the even trigger, bit 1 to the odd one.
  function automatic logic [1:0] pair_fire(input logic ha, input logic hb,
                                           input logic ta, input logic tb,
                                           input logic chained);
    logic joint;
    joint = ha && hb && (ta == tb);
    if (chained) return {joint, joint};
    return {hb, ha};
  endfunction

  // OR of the bits of v selected by mask.
  function automatic logic masked_any(input logic [31:0] v, input logic [31:0] mask);
    return |(v & mask);
  endfunction

endpackage

// File: rtl/trig_cfg_bank.sv
`timescale 1ns/1ps
module trig_cfg_bank
  import trig_pkg::*;
#(
  parameter int NUM_PAIRS     = 5,
  parameter int CMP_W         = 64,
  parameter int NO_CHAIN_PAIR = 1,
  localparam int NUM_TRIG     = 2 * NUM_PAIRS,
  localparam int IDX_W        = $clog2(NUM_TRIG)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we,
  input  logic [IDX_W-1:0]                   idx,
  input  trig_ctl_t                          ctl_in,
  input  logic                               chain_in,
  input  logic [CMP_W-1:0]                   cmp_in,
  output trig_ctl_t [NUM_TRIG-1:0]           ctl_q,
  output logic [NUM_TRIG-1:0][CMP_W-1:0]     cmp_q,
  output logic [NUM_PAIRS-1:0]               chain_q
);

  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
    logic sel_t;
    assign sel_t = we && (idx == IDX_W'(t));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_q[t] <= '0;
        cmp_q[t] <= '0;
      end else if (sel_t) begin
        ctl_q[t] <= ctl_in;
        cmp_q[t] <= cmp_in;
      end
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_chain
    if (p == NO_CHAIN_PAIR) begin : g_fixed
      assign chain_q[p] = 1'b0;
    end else begin : g_reg
      logic chain_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                chain_r <= 1'b0;
        else if (we && (idx == IDX_W'(2 * p)))     chain_r <= chain_in;
      end
      assign chain_q[p] = chain_r;
    end
  end

endmodule

// File: rtl/trig_pair_eval.sv
`timescale 1ns/1ps
module trig_pair_eval
  import trig_pkg::*;
#(
  parameter int NUM_PAIRS = 5,
  localparam int NUM_TRIG = 2 * NUM_PAIRS
) (
  input  logic                 valid,
  input  logic [NUM_TRIG-1:0]  hit,
  input  logic [NUM_TRIG-1:0]  en_vec,
  input  logic [NUM_TRIG-1:0]  tim_vec,
  input  logic [NUM_PAIRS-1:0] chain_vec,
  output logic [NUM_TRIG-1:0]  fire
);

  logic [NUM_TRIG-1:0] qual_hit;
  assign qual_hit = hit & en_vec & {NUM_TRIG{valid}};

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic [1:0] pf;
    assign pf = pair_fire(qual_hit[2*p], qual_hit[2*p+1],
                          tim_vec[2*p], tim_vec[2*p+1], chain_vec[p]);
    assign fire[2*p]   = pf[0];
    assign fire[2*p+1] = pf[1];
  end

endmodule

// File: rtl/trig_trap_ctl.sv
`timescale 1ns/1ps
module trig_trap_ctl #(
  parameter int NUM_TRIG = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid,
  input  logic [NUM_TRIG-1:0] fire,
  input  logic [NUM_TRIG-1:0] tim_vec,
  output logic                trap_now,
  output logic                trap_next_req,
  output logic                next_pending
);

  assign trap_now      = |(fire & ~tim_vec);
  assign trap_next_req = |(fire & tim_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     next_pending <= 1'b0;
    else if (valid) next_pending <= trap_next_req;
  end

endmodule

// File: rtl/trig_pair_resolver.sv
`timescale 1ns/1ps
module trig_pair_resolver
  import trig_pkg::*;
#(
  parameter int NUM_PAIRS                   = 5,
  parameter int CMP_W                       = 64,
  parameter int NO_CHAIN_PAIR               = 1,
  parameter logic [2*NUM_PAIRS-1:0] FETCH_MASK = 10'b01_0100_0011
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [$clog2(2*NUM_PAIRS)-1:0] cfg_idx,
  input  logic [1:0]                     cfg_mtype,
  input  logic                           cfg_select,
  input  logic                           cfg_timing,
  input  logic                           cfg_action,
  input  logic                           cfg_chain,
  input  logic                           cfg_enable,
  input  logic [CMP_W-1:0]               cfg_cmp,
  input  logic                           insn_valid,
  input  logic [2*NUM_PAIRS-1:0]         hit_raw,
  output logic [2*NUM_PAIRS-1:0]         fire,
  output logic                           trap_now,
  output logic                           trap_next_req,
  output logic                           next_pending,
  output logic                           fetch_hit,
  output logic                           mem_hit,
  output logic                           any_hit,
  output logic [4*NUM_PAIRS-1:0]         mtype_q,
  output logic [2*NUM_PAIRS-1:0]         select_q,
  output logic [2*NUM_PAIRS-1:0]         action_q,
  output logic [2*NUM_PAIRS*CMP_W-1:0]   cmp_q
);

  localparam int NUM_TRIG = 2 * NUM_PAIRS;

  trig_ctl_t                      ctl_in;
  trig_ctl_t [NUM_TRIG-1:0]       ctl_q;
  logic [NUM_TRIG-1:0][CMP_W-1:0] cmp_arr;
  logic [NUM_PAIRS-1:0]           chain_vec;
  logic [NUM_TRIG-1:0]            en_vec;
  logic [NUM_TRIG-1:0]            tim_vec;
  logic [NUM_TRIG-1:0]            qual_hit;

  assign ctl_in = '{mtype: cfg_mtype, sel: cfg_select, timing: cfg_timing,
                    action: cfg_action, enable: cfg_enable};

  trig_cfg_bank #(
    .NUM_PAIRS(NUM_PAIRS), .CMP_W(CMP_W), .NO_CHAIN_PAIR(NO_CHAIN_PAIR)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx),
    .ctl_in(ctl_in), .chain_in(cfg_chain), .cmp_in(cfg_cmp),
    .ctl_q(ctl_q), .cmp_q(cmp_arr), .chain_q(chain_vec)
  );

  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_out
    assign en_vec[t]            = ctl_q[t].enable;
    assign tim_vec[t]           = ctl_q[t].timing;
    assign select_q[t]          = ctl_q[t].sel;
    assign action_q[t]          = ctl_q[t].action;
    assign mtype_q[2*t +: 2]    = ctl_q[t].mtype;
    assign cmp_q[CMP_W*t +: CMP_W] = cmp_arr[t];
  end

  trig_pair_eval #(.NUM_PAIRS(NUM_PAIRS)) u_eval (
    .valid(insn_valid), .hit(hit_raw), .en_vec(en_vec), .tim_vec(tim_vec),
    .chain_vec(chain_vec), .fire(fire)
  );

  trig_trap_ctl #(.NUM_TRIG(NUM_TRIG)) u_trap (
    .clk(clk), .rst_n(rst_n), .valid(insn_valid), .fire(fire), .tim_vec(tim_vec),
    .trap_now(trap_now), .trap_next_req(trap_next_req), .next_pending(next_pending)
  );

  assign qual_hit  = hit_raw & en_vec & {NUM_TRIG{insn_valid}};
  assign fetch_hit = masked_any(32'(qual_hit), 32'(FETCH_MASK));
  assign mem_hit   = masked_any(32'(qual_hit), 32'(~FETCH_MASK));
  assign any_hit   = fetch_hit | mem_hit;

endmodule

// File: rtl/trig_resolver_chk.sv
`timescale 1ns/1ps
module trig_resolver_chk #(
  parameter int NUM_PAIRS     = 5,
  parameter int NO_CHAIN_PAIR = 1,
  localparam int NUM_TRIG     = 2 * NUM_PAIRS
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 insn_valid,
  input logic [NUM_TRIG-1:0]  hit_raw,
  input logic [NUM_TRIG-1:0]  fire,
  input logic                 trap_now,
  input logic                 trap_next_req,
  input logic                 next_pending,
  input logic [NUM_TRIG-1:0]  en_vec,
  input logic [NUM_TRIG-1:0]  tim_vec,
  input logic [NUM_PAIRS-1:0] chain_vec
);

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assert_unchained_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !chain_vec[p] |-> (fire[2*p] == (insn_valid && hit_raw[2*p] && en_vec[2*p])));
    assert_chain_joint_R4: assert property (@(posedge clk) disable iff (!rst_n)
      chain_vec[p] |-> (fire[2*p] == fire[2*p+1]));
    assert_timing_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (chain_vec[p] && (tim_vec[2*p] != tim_vec[2*p+1])) |-> (!fire[2*p] && !fire[2*p+1]));
  end

  assert_store_pair_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire[2*NO_CHAIN_PAIR+1] == (insn_valid && hit_raw[2*NO_CHAIN_PAIR+1] && en_vec[2*NO_CHAIN_PAIR+1]));

  assert_trap_has_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_now || trap_next_req) |-> (fire != '0));

  assert_pending_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && trap_next_req) |=> next_pending);

  assert_pending_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> $stable(next_pending));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |-> (fire == '0 && !trap_now && !trap_next_req));

endmodule

bind trig_pair_resolver trig_resolver_chk #(
  .NUM_PAIRS(NUM_PAIRS), .NO_CHAIN_PAIR(NO_CHAIN_PAIR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .hit_raw(hit_raw),
  .fire(fire), .trap_now(trap_now), .trap_next_req(trap_next_req),
  .next_pending(next_pending), .en_vec(en_vec), .tim_vec(tim_vec),
  .chain_vec(chain_vec)
);

// File: tb/trig_pair_resolver_tb.sv
`timescale 1ns/1ps
module trig_pair_resolver_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [1:0]  cfg_mtype = '0;
  logic        cfg_select = 1'b0, cfg_timing = 1'b0, cfg_action = 1'b0;
  logic        cfg_chain = 1'b0, cfg_enable = 1'b0;
  logic [63:0] cfg_cmp = '0;
  logic        insn_valid = 1'b0;
  logic [9:0]  hit_raw = '0;
  logic [9:0]  fire;
  logic        trap_now, trap_next_req, next_pending, fetch_hit, mem_hit, any_hit;
  logic [19:0] mtype_q;
  logic [9:0]  select_q, action_q;
  logic [639:0] cmp_q;

  trig_pair_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_mtype(cfg_mtype), .cfg_select(cfg_select), .cfg_timing(cfg_timing),
    .cfg_action(cfg_action), .cfg_chain(cfg_chain), .cfg_enable(cfg_enable),
    .cfg_cmp(cfg_cmp), .insn_valid(insn_valid), .hit_raw(hit_raw), .fire(fire),
    .trap_now(trap_now), .trap_next_req(trap_next_req), .next_pending(next_pending),
    .fetch_hit(fetch_hit), .mem_hit(mem_hit), .any_hit(any_hit),
    .mtype_q(mtype_q), .select_q(select_q), .action_q(action_q), .cmp_q(cmp_q)
  );

  always #4 clk = ~clk;

  // Behavioural reference state
  logic [9:0]  m_en = '0, m_tim = '0, m_sel = '0, m_act = '0;
  logic [1:0]  m_mt  [10];
  logic [63:0] m_cmp [10];
  logic [4:0]  m_ch = '0;
  logic        m_pend = 1'b0;

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_tag = "R1";

  task automatic check(string tag, string what, logic [639:0] act, logic [639:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [9:0] ref_fire();
    logic [9:0] r;
    r = '0;
    for (int p = 0; p < 5; p++) begin
      logic ha, hb;
      ha = insn_valid && hit_raw[2*p] && m_en[2*p];
      hb = insn_valid && hit_raw[2*p+1] && m_en[2*p+1];
      if (m_ch[p]) begin
        if (ha && hb && m_tim[2*p] == m_tim[2*p+1]) begin
          r[2*p] = 1'b1; r[2*p+1] = 1'b1;
        end
      end else begin
        r[2*p] = ha; r[2*p+1] = hb;
      end
    end
    return r;
  endfunction

  task automatic compare();
    logic [9:0]   ef, q;
    logic         fh, mh;
    logic [19:0]  emt;
    logic [639:0] ecmp;
    ef = ref_fire();
    q  = hit_raw & m_en & {10{insn_valid}};
    fh = q[0] | q[1] | q[6] | q[8];
    mh = q[2] | q[3] | q[4] | q[5] | q[7] | q[9];
    for (int t = 0; t < 10; t++) begin
      emt[2*t +: 2]   = m_mt[t];
      ecmp[64*t +: 64] = m_cmp[t];
    end
    check(cur_tag, "fire", 640'(fire), 640'(ef));
    check("R8", "trap_now", 640'(trap_now), 640'(|(ef & ~m_tim)));
    check("R8", "trap_next_req", 640'(trap_next_req), 640'(|(ef & m_tim)));
    check("R9", "next_pending", 640'(next_pending), 640'(m_pend));
    check("R10", "hit summary", 640'({fetch_hit, mem_hit, any_hit}), 640'({fh, mh, fh | mh}));
    check("R2", "mtype/select/action", 640'({mtype_q, select_q, action_q}), 640'({emt, m_sel, m_act}));
    check("R2", "compare values", cmp_q, ecmp);
  endtask

  task automatic cyc();
    #3;
    compare();
    @(posedge clk);
    if (insn_valid) m_pend = |(ref_fire() & m_tim);
    if (cfg_we && cfg_idx < 4'd10) begin
      m_en[cfg_idx]  = cfg_enable;
      m_tim[cfg_idx] = cfg_timing;
      m_sel[cfg_idx] = cfg_select;
      m_act[cfg_idx] = cfg_action;
      m_mt[cfg_idx]  = cfg_mtype;
      m_cmp[cfg_idx] = cfg_cmp;
      if (cfg_idx[0] == 1'b0 && cfg_idx != 4'd2) m_ch[cfg_idx[3:1]] = cfg_chain;
    end
    @(negedge clk);
  endtask

  task automatic wr(int idx, bit en, bit tim, bit ch, logic [63:0] cmp);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_enable = en; cfg_timing = tim;
    cfg_chain = ch; cfg_cmp = cmp; cfg_mtype = 2'(idx + 1);
    cfg_select = idx[0]; cfg_action = idx[1];
    cyc();
    cfg_we = 1'b0;
  endtask

  task automatic hit(logic [9:0] h, bit v);
    hit_raw = h; insn_valid = v;
    cyc();
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int t = 0; t < 10; t++) begin m_mt[t] = '0; m_cmp[t] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: nothing enabled, all hits raised
    cur_tag = "R1";
    hit(10'h3FF, 1'b1);
    hit(10'h000, 1'b0);

    // R2: load all triggers, timing 0, unchained; out-of-range write ignored
    cur_tag = "R2";
    for (int t = 0; t < 10; t++) wr(t, 1'b1, 1'b0, 1'b0, 64'hA5A5_0000_0000_0000 | 64'(t * 4099));
    wr(12, 1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(15, 1'b0, 1'b1, 1'b1, 64'h1234);
    hit(10'h000, 1'b0);

    // R3: independent firing under several patterns
    cur_tag = "R3";
    hit(10'b00_0000_0001, 1'b1);
    hit(10'b10_1010_1010, 1'b1);
    hit(10'b01_0101_0101, 1'b1);
    hit(10'h3FF, 1'b1);

    // R11: invalid instruction fires nothing
    cur_tag = "R11";
    hit(10'h3FF, 1'b0);

    // R7: chain field on odd index leaves pair 0 independent
    cur_tag = "R7";
    wr(1, 1'b1, 1'b0, 1'b1, 64'h11);
    hit(10'b00_0000_0001, 1'b1);
    hit(10'b00_0000_0010, 1'b1);

    // R4: chain pair 0 through the even index
    cur_tag = "R4";
    wr(0, 1'b1, 1'b0, 1'b1, 64'h22);
    hit(10'b00_0000_0001, 1'b1);
    hit(10'b00_0000_0010, 1'b1);
    hit(10'b00_0000_0011, 1'b1);
    wr(1, 1'b0, 1'b0, 1'b0, 64'h33);
    hit(10'b00_0000_0011, 1'b1);
    wr(1, 1'b1, 1'b0, 1'b0, 64'h33);

    // R5: chained pair 4 with disagreeing timing
    cur_tag = "R5";
    wr(8, 1'b1, 1'b0, 1'b1, 64'h88);
    wr(9, 1'b1, 1'b1, 1'b0, 64'h99);
    hit(10'b11_0000_0000, 1'b1);
    wr(8, 1'b1, 1'b1, 1'b1, 64'h88);
    hit(10'b11_0000_0000, 1'b1);

    // R6: chain request on the store pair is ignored
    cur_tag = "R6";
    wr(2, 1'b1, 1'b0, 1'b1, 64'h44);
    hit(10'b00_0000_0100, 1'b1);
    hit(10'b00_0000_1000, 1'b1);

    // R9: next-instruction trap pending across idle cycles
    cur_tag = "R9";
    wr(5, 1'b1, 1'b1, 1'b0, 64'h55);
    hit(10'b00_0010_0000, 1'b1);
    hit(10'h000, 1'b0);
    hit(10'h3FF, 1'b0);
    hit(10'h000, 1'b1);
    hit(10'h000, 1'b1);

    // Mixed traffic
    cur_tag = "R4";
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 6 == 0)
        wr(int'($urandom % 12), 1'($urandom), 1'($urandom), 1'($urandom),
           {$urandom, $urandom});
      else
        hit(10'($urandom), ($urandom % 4) != 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule